// File: doc/BRIEF.md
# Device Controller Command Register

A 32-bit command and control register for the device side of a USB controller. Software writes a whole word each time through a simple write strobe, and the register's current value is always visible on a read bus. The register holds the run/stop state that governs attach and detach, a controller reset request that clears itself, two semaphore bits that software uses while it touches shared descriptor structures, and an 8-bit interrupt threshold.

The rest of the controller connects to the outputs. The run state and the pull-up enable drive the line interface. The reset request is held until the controller reports that its reset is finished. The threshold sets how often the interrupt logic may fire. Hazard pulses from the setup-packet path and from the endpoint engine clear the matching semaphore bit, so software can tell that its copy or append raced the hardware and must be repeated.

Top module: `devctl_cmd_reg`

## Requirements
- R1: After reset the read value is 0x00080000. run_o, pullup_en and ctrl_reset_req are 0 and int_thresh is 8.
- R2: A write sets the run state to write bit 0 from the next cycle on, unless a controller reset is in progress. The run state shows on run_o and on read bit 0.
- R3: pullup_en is 1 exactly when the run state is 1 and hs_mode is 0, with no delay from hs_mode.
- R4: A write with bit 1 set, while no reset is in progress, asserts ctrl_reset_req and read bit 1 from the next cycle. Both stay high until the cycle after reset_done is sampled high.
- R5: During a reset, writes that have bit 1 clear do not end the reset early. Only reset_done ends it.
- R6: While a reset is in progress the run state is 0, and a write of bit 0 = 1 is ignored.
- R7: Read bit 13 (setup semaphore) takes write bit 13 on each write. A setup_hazard pulse clears it in the next cycle, and the hazard wins over a write of 1 in the same cycle.
- R8: Read bit 14 (descriptor-append semaphore) takes write bit 14 on each write. A dtd_hazard pulse clears it in the next cycle, and the hazard wins over a write of 1 in the same cycle.
- R9: Read bits 23:16 and int_thresh take write bits 23:16 on each write and hold their value when there is no write.
- R10: Read bits 31:24, 15 and 12:2 are always 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| setup_hazard | input | 1 | Setup packet arrived during a payload copy |
| dtd_hazard | input | 1 | Endpoint engine is in the append-miss window |
| reset_done | input | 1 | Controller finished its internal reset |
| hs_mode | input | 1 | Link is in high-speed mode |
| run_o | output | 1 | Run state |
| pullup_en | output | 1 | D+ pull-up enable |
| ctrl_reset_req | output | 1 | Reset request to the controller |
| int_thresh | output | 8 | Interrupt threshold |

## Verification
The bench writes 0 to the reset bit in the middle of a reset. A design that lets software cancel the reset would drop ctrl_reset_req early. It writes run = 1 during a reset, which a design would pass through if it does not force the run state low. It drives a hazard in the same cycle as a write of 1 to a semaphore bit. If the priority is wrong, the bit would read back as 1. It also raises hs_mode while the controller is running, and a pull-up that copies run/stop would stay on. Random writes with all bits set show any reserved bit that keeps written data.

// File: rtl/devctl_cmd_pkg.sv
package devctl_cmd_pkg;
    localparam int RUN_BIT  = 0;
    localparam int RST_BIT  = 1;
    localparam int SUTW_BIT = 13;
    localparam int ADTW_BIT = 14;
    localparam int THR_LSB  = 16;
    localparam int NUM_TRIP = 2;

    function automatic int trip_pos(input int idx);
        return (idx == 0) ? SUTW_BIT : ADTW_BIT;
    endfunction
endpackage

// File: rtl/devctl_rst_seq.sv
module devctl_rst_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o
);
    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (busy_q) begin
            if (done_i) busy_d = 1'b0;
        end else if (start_i) begin
            busy_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy_o = busy_q;

    // R5
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_i) |=> busy_q);
    // R4
    rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done_i) |=> !busy_q);
endmodule

// File: rtl/devctl_tripwire.sv
module devctl_tripwire (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic hazard,
    output logic q_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (hazard)     bit_d = 1'b0;
        else if (wr_en) bit_d = wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign q_o = bit_q;

    // R7 R8
    trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |=> !q_o);
endmodule

// File: rtl/devctl_cmd_reg.sv
module devctl_cmd_reg #(
    parameter int DATA_W    = 32,
    parameter int THR_W     = 8,
    parameter int THR_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              setup_hazard,
    input  logic              dtd_hazard,
    input  logic              reset_done,
    input  logic              hs_mode,
    output logic              run_o,
    output logic              pullup_en,
    output logic              ctrl_reset_req,
    output logic [THR_W-1:0]  int_thresh
);
    import devctl_cmd_pkg::*;

    localparam int THR_MSB = THR_LSB + THR_W - 1;

    typedef struct packed {
        logic             run;
        logic [THR_W-1:0] thr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic busy;
    logic start_rst;
    logic [NUM_TRIP-1:0] haz;
    logic [NUM_TRIP-1:0] trip;

    assign start_rst = wr_en && wr_data[RST_BIT];
    assign haz       = {dtd_hazard, setup_hazard};

    devctl_rst_seq u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_rst),
        .done_i  (reset_done),
        .busy_o  (busy)
    );

    for (genvar i = 0; i < NUM_TRIP; i++) begin : g_trip
        devctl_tripwire u_tw (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[trip_pos(i)]),
            .hazard (haz[i]),
            .q_o    (trip[i])
        );
    end

    // Whether the sequencer will be busy on the next cycle.
    logic busy_next;
    assign busy_next = busy ? !reset_done : start_rst;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.run = wr_data[RUN_BIT];
            ctl_d.thr = wr_data[THR_MSB:THR_LSB];
        end
        if (busy_next) ctl_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.run <= 1'b0;
            ctl_q.thr <= THR_W'(THR_RESET);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[RUN_BIT]         = ctl_q.run;
        rd_data[RST_BIT]         = busy;
        rd_data[SUTW_BIT]        = trip[0];
        rd_data[ADTW_BIT]        = trip[1];
        rd_data[THR_MSB:THR_LSB] = ctl_q.thr;
    end

    assign run_o          = ctl_q.run;
    assign pullup_en      = ctl_q.run && !hs_mode;
    assign ctrl_reset_req = busy;
    assign int_thresh     = ctl_q.thr;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DATA_W-1:THR_MSB+1], wr_data[15],
                              wr_data[12:2]};

    // R6
    run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset_req |-> !run_o);
    // R9
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(int_thresh));
    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ctrl_reset_req && !start_rst) |=> $stable(run_o));
endmodule

// File: tb/tb_devctl_cmd_reg.sv
module tb_devctl_cmd_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        setup_hazard = 1'b0, dtd_hazard = 1'b0;
    logic        reset_done = 1'b0, hs_mode = 1'b0;
    logic        run_o, pullup_en, ctrl_reset_req;
    logic [7:0]  int_thresh;

    int checks = 0;
    int fails  = 0;

    // Model of the register state.
    logic       m_run = 0, m_busy = 0, m_su = 0, m_ad = 0;
    logic [7:0] m_thr = 8'd8;

    always #5 clk = ~clk;

    devctl_cmd_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .setup_hazard(setup_hazard),
        .dtd_hazard(dtd_hazard), .reset_done(reset_done),
        .hs_mode(hs_mode), .run_o(run_o), .pullup_en(pullup_en),
        .ctrl_reset_req(ctrl_reset_req), .int_thresh(int_thresh)
    );

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        v[0] = m_run; v[1] = m_busy; v[13] = m_su; v[14] = m_ad;
        v[23:16] = m_thr;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, rd_data, exp_rd());
        check(req, {31'd0, pullup_en}, {31'd0, m_run && !hs_mode});
        check(req, {31'd0, run_o}, {31'd0, m_run});
        check(req, {31'd0, ctrl_reset_req}, {31'd0, m_busy});
        check(req, {24'd0, int_thresh}, {24'd0, m_thr});
    endtask

    // Drive one cycle of inputs, check outputs for the current state,
    // then advance the model across the next rising edge.
    task automatic step(input logic we, input logic [31:0] wd,
                        input logic sh, input logic dh, input logic dn,
                        input logic hs, input string req);
        logic busy_n;
        @(negedge clk);
        wr_en = we; wr_data = wd; setup_hazard = sh; dtd_hazard = dh;
        reset_done = dn; hs_mode = hs;
        #1;
        check_all(req);
        busy_n = m_busy ? !dn : (we && wd[1]);
        if (we) begin
            m_run = wd[0]; m_thr = wd[23:16];
        end
        if (busy_n) m_run = 1'b0;
        m_su = sh ? 1'b0 : (we ? wd[13] : m_su);
        m_ad = dh ? 1'b0 : (we ? wd[14] : m_ad);
        m_busy = busy_n;
    endtask

    task automatic idle(input string req);
        step(0, '0, 0, 0, 0, hs_mode, req);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        idle("R1");
        check("R1", rd_data, 32'h0008_0000);
        // R2 run on
        step(1, 32'h0008_0001, 0, 0, 0, 0, "R2");
        idle("R2");
        // R3 high-speed kills the pull-up
        step(0, '0, 0, 0, 0, 1, "R3");
        step(0, '0, 0, 0, 0, 0, "R3");
        // R4 reset with run=1 in the same write
        step(1, 32'h0008_0003, 0, 0, 0, 0, "R4");
        idle("R4");
        // R5 write 0 to reset bit during reset
        step(1, 32'h0008_0000, 0, 0, 0, 0, "R5");
        idle("R5");
        // R6 write run=1 during reset
        step(1, 32'h0008_0001, 0, 0, 0, 0, "R6");
        idle("R6");
        step(0, '0, 0, 0, 1, 0, "R4");
        idle("R4");
        // R7 setup semaphore: set, then hazard with write 1
        step(1, 32'h0008_2000, 0, 0, 0, 0, "R7");
        step(1, 32'h0008_2000, 1, 0, 0, 0, "R7");
        idle("R7");
        // R8 append semaphore
        step(1, 32'h0008_4000, 0, 0, 0, 0, "R8");
        step(1, 32'h0008_4000, 0, 1, 0, 0, "R8");
        idle("R8");
        // R9 threshold
        step(1, 32'h0040_0000, 0, 0, 0, 0, "R9");
        idle("R9");
        check("R9", {24'd0, int_thresh}, 32'h40);
        // R10 reserved bits stay 0
        step(1, 32'hFFFF_FFFD, 0, 0, 0, 0, "R10");
        idle("R10");
        check("R10", rd_data & 32'hFF00_9FFC, 32'h0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic we, sh, dh, dn, hs;
            logic [31:0] wd;
            we = ($urandom_range(0, 9) < 3);
            wd = $urandom();
            if ($urandom_range(0, 3) != 0) wd[1] = 1'b0;
            if ($urandom_range(0, 1) == 0) wd = wd | 32'hFF00_9FFC;
            sh = ($urandom_range(0, 15) == 0);
            dh = ($urandom_range(0, 15) == 0);
            dn = ($urandom_range(0, 5) == 0);
            hs = ($urandom_range(0, 3) == 0);
            step(we, wd, sh, dh, dn, hs, "R2 R3 R4 R5 R6 R7 R8 R9 R10");
            check("R10", rd_data & 32'hFF00_9FFC, 32'h0);
        end
        idle("R9");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end
endmodule